// File: doc/BRIEF.md
# Write-Once Synchronizing Memory

A small memory in which every word is written at most once per lifetime and read any number of times. Each location is in one of three states: unallocated, allocated but empty, or full. A read request carries a return tag. If the location is full, the data and tag come back at once. If the location is still empty, the read is parked in hardware and produces no traffic until the single write to that location arrives. That write fills the word and then answers every parked reader, oldest first, one reply per cycle.

Parked reads live in a shared pool of fixed depth. Each entry holds a tag and a link to the next entry for the same location, so each location keeps its own ordered list. Allocate and release requests move a location between unallocated and empty. Misuse does not stall the block. A second write, a release while readers wait, or access to an unallocated word each raise a one-cycle error pulse, and the request is then dropped.

Top module: `istruct_mem`

## Requirements
- R1: A fetch (`req_op_i` = 0) accepted at a full location raises `rsp_valid_o` in the cycle after acceptance, with `rsp_tag_o` equal to the request tag and `rsp_data_o` equal to the stored word.
- R2: A fetch accepted at an empty location produces no response and no error until that location is written.
- R3: A store (`req_op_i` = 1) accepted at an empty location makes it full. If readers are parked there, they are answered one per cycle in arrival order, starting the cycle after the store, each reply carrying the stored data.
- R4: A store accepted at a full location pulses `err_rewrite_o` for one cycle and leaves the stored word unchanged.
- R5: A release (`req_op_i` = 3) accepted at a location with parked readers pulses `err_free_busy_o` and changes nothing. The readers are still answered by the later store.
- R6: A fetch, store or release of an unallocated location, or an allocate (`req_op_i` = 2) of an allocated one, pulses `err_bad_state_o` and produces no response.
- R7: An allocate makes an unallocated location empty. A release of an allocated location with no parked readers makes it unallocated.
- R8: When every pool entry is in use, `req_ready_o` is low while a fetch is presented. Stores, allocates and releases are still accepted.
- R9: `req_ready_o` is low while parked readers are being answered. It is also low for a presented fetch while a reply is held by a low `rsp_ready_i`.
- R10: While `rsp_valid_o` is high and `rsp_ready_i` is low, the reply and its tag and data stay unchanged.
- R11: After reset all locations are unallocated, the pool is empty, `rsp_valid_o` and the error flags are low, and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_op_i | input | 2 | 0 fetch, 1 store, 2 allocate, 3 release |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | DATA_W | Store data |
| req_tag_i | input | TAG_W | Return tag for a fetch |
| rsp_valid_o | output | 1 | Reply present |
| rsp_ready_i | input | 1 | Reply taken this cycle when high with valid |
| rsp_tag_o | output | TAG_W | Tag of the answered fetch |
| rsp_data_o | output | DATA_W | Word returned |
| err_rewrite_o | output | 1 | Pulse: store to a full location |
| err_free_busy_o | output | 1 | Pulse: release with readers parked |
| err_bad_state_o | output | 1 | Pulse: access or allocate in the wrong allocation state |

## Verification
The assertions assume that requests follow a valid/ready handshake. They also assume that the reply consumer eventually raises `rsp_ready_i`, because a drain that is never taken holds the block forever. Request fields are taken to be stable only in the accepting cycle. The stimulus drives every field at a falling edge and holds it until a rising edge at which `req_ready_o` is high, then drops valid. `rsp_ready_i` is held low only for a bounded number of cycles, inside the back-pressure test.

// File: rtl/ism_pkg.sv
package ism_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_STORE = 2'd1,
    OP_ALLOC = 2'd2,
    OP_FREE  = 2'd3
  } ism_op_e;

  typedef enum logic [1:0] {
    LOC_UNALLOC = 2'd0,
    LOC_EMPTY   = 2'd1,
    LOC_FULL    = 2'd2
  } loc_st_e;
endpackage

// File: rtl/ism_defer_pool.sv
module ism_defer_pool #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             link_i,
  input  logic [IDX_W-1:0] link_prev_i,
  input  logic             pop_i,
  input  logic [IDX_W-1:0] pop_idx_i,
  output logic [IDX_W-1:0] free_idx_o,
  output logic             full_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [IDX_W-1:0] rd_next_o
);
  logic [DEPTH-1:0] used_q;
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [IDX_W-1:0] next_q [DEPTH];
  logic [DEPTH-1:0] sel_free;

  // one-hot lowest free entry
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
      if (g == 0) begin : g_first
        assign sel_free[g] = !used_q[g];
      end else begin : g_rest
        assign sel_free[g] = !used_q[g] && (&used_q[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    free_idx_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sel_free[i]) free_idx_o = IDX_W'(i);
  end

  assign full_o    = &used_q;
  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_next_o = next_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else begin
      if (pop_i)  used_q[pop_idx_i]  <= 1'b0;
      if (push_i) used_q[free_idx_o] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) tag_q[free_idx_o] <= push_tag_i;
    if (push_i && link_i) next_q[link_prev_i] <= free_idx_o;
  end

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r3_pop_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> used_q[pop_idx_i]);
endmodule

// File: rtl/ism_loc_table.sv
module ism_loc_table
  import ism_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output loc_st_e           st_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pend_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o,
  input  logic              set_st_i,
  input  loc_st_e           st_val_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              park_i,
  input  logic [IDX_W-1:0]  park_idx_i,
  input  logic              clr_pend_i,
  input  logic [ADDR_W-1:0] clr_addr_i
);
  localparam int NLOC = 1 << ADDR_W;

  loc_st_e           st_q   [NLOC];
  logic [NLOC-1:0]   pend_q;
  logic [DATA_W-1:0] data_q [NLOC];
  logic [IDX_W-1:0]  head_q [NLOC];
  logic [IDX_W-1:0]  tail_q [NLOC];

  assign st_o   = st_q[addr_i];
  assign data_o = data_q[addr_i];
  assign pend_o = pend_q[addr_i];
  assign head_o = head_q[addr_i];
  assign tail_o = tail_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NLOC; i++) st_q[i] <= LOC_UNALLOC;
      pend_q <= '0;
    end else begin
      if (set_st_i)    st_q[addr_i] <= st_val_i;
      else if (fill_i) st_q[addr_i] <= LOC_FULL;
      if (clr_pend_i)  pend_q[clr_addr_i] <= 1'b0;
      if (park_i)      pend_q[addr_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) data_q[addr_i] <= fill_data_i;
    if (park_i) begin
      tail_q[addr_i] <= park_idx_i;
      if (!pend_q[addr_i]) head_q[addr_i] <= park_idx_i;
    end
  end

  a_r4_fill_only_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> st_q[addr_i] == LOC_EMPTY);
  a_r2_park_only_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_i |-> st_q[addr_i] == LOC_EMPTY);
endmodule

// File: rtl/istruct_mem.sv
module istruct_mem
  import ism_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int TAG_W      = 4,
  parameter int POOL_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              err_rewrite_o,
  output logic              err_free_busy_o,
  output logic              err_bad_state_o
);
  localparam int IDX_W = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1;

  ism_op_e           op;
  loc_st_e           st;
  logic [DATA_W-1:0] st_data;
  logic              pend;
  logic [IDX_W-1:0]  head, tail, free_idx, rd_next;
  logic [TAG_W-1:0]  rd_tag;
  logic              pool_full, slot_free, acc;
  logic              hit, park, fill, rewrite, bad, free_busy, do_alloc, do_free;
  logic              set_st, step, last;
  loc_st_e           st_val;

  logic              drain_q;
  logic [IDX_W-1:0]  cur_q, last_q;
  logic [ADDR_W-1:0] daddr_q;
  logic [DATA_W-1:0] ddata_q;

  assign op        = ism_op_e'(req_op_i);
  assign slot_free = !rsp_valid_o || rsp_ready_i;
  assign req_ready_o = !drain_q && !(op == OP_FETCH && (pool_full || !slot_free));
  assign acc       = req_valid_i && req_ready_o;

  always_comb begin
    hit       = acc && op == OP_FETCH && st == LOC_FULL;
    park      = acc && op == OP_FETCH && st == LOC_EMPTY;
    fill      = acc && op == OP_STORE && st == LOC_EMPTY;
    rewrite   = acc && op == OP_STORE && st == LOC_FULL;
    bad       = acc && (((op == OP_FETCH || op == OP_STORE || op == OP_FREE) && st == LOC_UNALLOC)
                        || (op == OP_ALLOC && st != LOC_UNALLOC));
    free_busy = acc && op == OP_FREE && st != LOC_UNALLOC && pend;
    do_alloc  = acc && op == OP_ALLOC && st == LOC_UNALLOC;
    do_free   = acc && op == OP_FREE && st != LOC_UNALLOC && !pend;
    set_st    = do_alloc || do_free;
    st_val    = do_alloc ? LOC_EMPTY : LOC_UNALLOC;
  end

  assign step = drain_q && slot_free;
  assign last = cur_q == last_q;

  ism_loc_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_tab (
    .clk_i, .rst_ni,
    .addr_i(req_addr_i), .st_o(st), .data_o(st_data), .pend_o(pend),
    .head_o(head), .tail_o(tail),
    .set_st_i(set_st), .st_val_i(st_val),
    .fill_i(fill), .fill_data_i(req_data_i),
    .park_i(park), .park_idx_i(free_idx),
    .clr_pend_i(step && last), .clr_addr_i(daddr_q)
  );

  ism_defer_pool #(.DEPTH(POOL_DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_pool (
    .clk_i, .rst_ni,
    .push_i(park), .push_tag_i(req_tag_i),
    .link_i(pend), .link_prev_i(tail),
    .pop_i(step), .pop_idx_i(cur_q),
    .free_idx_o(free_idx), .full_o(pool_full),
    .rd_idx_i(cur_q), .rd_tag_o(rd_tag), .rd_next_o(rd_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q <= 1'b0;
      cur_q   <= '0;
      last_q  <= '0;
      daddr_q <= '0;
      ddata_q <= '0;
    end else if (fill && pend) begin
      drain_q <= 1'b1;
      cur_q   <= head;
      last_q  <= tail;
      daddr_q <= req_addr_i;
      ddata_q <= req_data_i;
    end else if (step) begin
      cur_q <= rd_next;
      if (last) drain_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_tag_o   <= '0;
      rsp_data_o  <= '0;
    end else if (hit) begin
      rsp_valid_o <= 1'b1;
      rsp_tag_o   <= req_tag_i;
      rsp_data_o  <= st_data;
    end else if (step) begin
      rsp_valid_o <= 1'b1;
      rsp_tag_o   <= rd_tag;
      rsp_data_o  <= ddata_q;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_rewrite_o   <= 1'b0;
      err_free_busy_o <= 1'b0;
      err_bad_state_o <= 1'b0;
    end else begin
      err_rewrite_o   <= rewrite;
      err_free_busy_o <= free_busy;
      err_bad_state_o <= bad;
    end
  end

  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_data_o));
  a_r3_drain_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_q && slot_free |=> rsp_valid_o);
  a_r6_err_no_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> !err_bad_state_o);
endmodule

// File: tb/sim_istruct_mem.sv
module sim_istruct_mem;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [1:0] req_op_i = 2'd0;
  logic [2:0] req_addr_i = '0;
  logic [7:0] req_data_i = '0;
  logic [3:0] req_tag_i = '0;
  logic       rsp_valid_o;
  logic       rsp_ready_i = 1'b1;
  logic [3:0] rsp_tag_o;
  logic [7:0] rsp_data_o;
  logic       err_rewrite_o, err_free_busy_o, err_bad_state_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  istruct_mem u0 (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_data_i, .req_tag_i, .rsp_valid_o, .rsp_ready_i, .rsp_tag_o, .rsp_data_o,
    .err_rewrite_o, .err_free_busy_o, .err_bad_state_o
  );

  typedef struct packed {
    logic [1:0] op;
    logic [2:0] addr;
    logic [7:0] data;
    logic [3:0] tag;
    logic       rsp;
    logic [3:0] etag;
    logic [7:0] edata;
    logic [2:0] err;  // {rewrite, free_busy, bad_state}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 3'd0, 8'h00, 4'd0, 1'b0, 4'd0, 8'h00, 3'b000}, // R7 allocate
    '{2'd1, 3'd0, 8'h5A, 4'd0, 1'b0, 4'd0, 8'h00, 3'b000}, // R3 store, no readers
    '{2'd0, 3'd0, 8'h00, 4'd3, 1'b1, 4'd3, 8'h5A, 3'b000}, // R1
    '{2'd0, 3'd0, 8'h00, 4'd7, 1'b1, 4'd7, 8'h5A, 3'b000}, // R1
    '{2'd1, 3'd0, 8'h11, 4'd0, 1'b0, 4'd0, 8'h00, 3'b100}, // R4 rewrite
    '{2'd0, 3'd0, 8'h00, 4'd1, 1'b1, 4'd1, 8'h5A, 3'b000}, // R4 data kept
    '{2'd0, 3'd5, 8'h00, 4'd2, 1'b0, 4'd0, 8'h00, 3'b001}, // R6 unallocated
    '{2'd2, 3'd0, 8'h00, 4'd0, 1'b0, 4'd0, 8'h00, 3'b001}, // R6 double alloc
    '{2'd3, 3'd0, 8'h00, 4'd0, 1'b0, 4'd0, 8'h00, 3'b000}, // R7 release
    '{2'd0, 3'd0, 8'h00, 4'd2, 1'b0, 4'd0, 8'h00, 3'b001}, // R7 released
    '{2'd2, 3'd0, 8'h00, 4'd0, 1'b0, 4'd0, 8'h00, 3'b000}, // R7 realloc
    '{2'd0, 3'd0, 8'h00, 4'd4, 1'b0, 4'd0, 8'h00, 3'b000}, // R2 parked
    '{2'd3, 3'd0, 8'h00, 4'd0, 1'b0, 4'd0, 8'h00, 3'b010}  // R5 busy release
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // drive at negedge, hold to an accepting posedge, return at the next negedge
  task automatic issue(input logic [1:0] op, input logic [2:0] addr,
                       input logic [7:0] data, input logic [3:0] tag);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = addr;
    req_data_i = data; req_tag_i = tag;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  function automatic logic [2:0] errs();
    return {err_rewrite_o, err_free_busy_o, err_bad_state_o};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ready", {31'd0, req_ready_o}, 32'd1);
    check("R11 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
    check("R11 errors", {29'd0, errs()}, 32'd0);
    rst_ni = 1'b1;
    issue(2'd0, 3'd1, 8'h00, 4'd0);
    check("R11 unallocated", {29'd0, errs()}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].tag);
      check($sformatf("vec%0d rsp_valid", i), {31'd0, rsp_valid_o}, {31'd0, VEC[i].rsp});
      if (VEC[i].rsp) begin
        check($sformatf("vec%0d tag", i), {28'd0, rsp_tag_o}, {28'd0, VEC[i].etag});
        check($sformatf("vec%0d data", i), {24'd0, rsp_data_o}, {24'd0, VEC[i].edata});
      end
      check($sformatf("vec%0d errors", i), {29'd0, errs()}, {29'd0, VEC[i].err});
    end
    @(negedge clk);
    check("R2 still silent", {31'd0, rsp_valid_o}, 32'd0);

    // R5: reader parked on a0 survives rejected release, answered by store
    issue(2'd1, 3'd0, 8'h33, 4'd0);
    check("R9 ready low in drain", {31'd0, req_ready_o}, 32'd0);
    @(negedge clk);
    check("R5 reply valid", {31'd0, rsp_valid_o}, 32'd1);
    check("R5 reply tag", {28'd0, rsp_tag_o}, 32'd4);
    check("R5 reply data", {24'd0, rsp_data_o}, 32'h33);
    @(negedge clk);
    check("R3 single reply", {31'd0, rsp_valid_o}, 32'd0);

    // R8 pool full, R3 order
    issue(2'd2, 3'd1, 8'h00, 4'd0);
    for (int k = 0; k < 4; k++) begin
      issue(2'd0, 3'd1, 8'h00, 4'(9 + k));
      check("R2 park silent", {31'd0, rsp_valid_o}, 32'd0);
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = 2'd0; req_addr_i = 3'd2; req_tag_i = 4'd0;
    #1;
    check("R8 fetch blocked when full", {31'd0, req_ready_o}, 32'd0);
    req_op_i = 2'd1; req_addr_i = 3'd1; req_data_i = 8'hC3;
    #1;
    check("R8 store accepted when full", {31'd0, req_ready_o}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R9 ready low at drain start", {31'd0, req_ready_o}, 32'd0);
    check("R3 no reply in store cycle", {31'd0, rsp_valid_o}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 drain valid", {31'd0, rsp_valid_o}, 32'd1);
      check("R3 drain order", {28'd0, rsp_tag_o}, 32'(9 + k));
      check("R3 drain data", {24'd0, rsp_data_o}, 32'hC3);
    end
    @(negedge clk);
    check("R3 drain ends", {31'd0, rsp_valid_o}, 32'd0);
    issue(2'd0, 3'd1, 8'h00, 4'd6);
    check("R1 after drain", {24'd0, rsp_data_o}, 32'hC3);

    // R10 back-pressure during drain
    issue(2'd2, 3'd2, 8'h00, 4'd0);
    issue(2'd0, 3'd2, 8'h00, 4'd1);
    issue(2'd0, 3'd2, 8'h00, 4'd2);
    rsp_ready_i = 1'b0;
    issue(2'd1, 3'd2, 8'h77, 4'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 held valid", {31'd0, rsp_valid_o}, 32'd1);
      check("R10 held tag", {28'd0, rsp_tag_o}, 32'd1);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk);
    check("R3 second reply tag", {28'd0, rsp_tag_o}, 32'd2);
    check("R3 second reply data", {24'd0, rsp_data_o}, 32'h77);
    rsp_ready_i = 1'b0;
    req_valid_i = 1'b0; req_op_i = 2'd0; req_addr_i = 3'd2;
    #1;
    check("R9 fetch blocked by held reply", {31'd0, req_ready_o}, 32'd0);
    req_op_i = 2'd1; req_addr_i = 3'd3;
    #1;
    check("R9 store open with held reply", {31'd0, req_ready_o}, 32'd1);
    rsp_ready_i = 1'b1;
    @(negedge clk);
    check("R10 reply taken", {31'd0, rsp_valid_o}, 32'd0);

    // R7 release of full location, then fresh lifetime
    issue(2'd3, 3'd2, 8'h00, 4'd0);
    check("R7 release ok", {29'd0, errs()}, 32'd0);
    issue(2'd0, 3'd2, 8'h00, 4'd8);
    check("R7 released rejects fetch", {29'd0, errs()}, 32'd1);
    issue(2'd2, 3'd2, 8'h00, 4'd0);
    issue(2'd0, 3'd2, 8'h00, 4'd8);
    check("R7 realloc empty", {31'd0, rsp_valid_o}, 32'd0);
    issue(2'd1, 3'd2, 8'h44, 4'd0);
    @(negedge clk);
    check("R7 new write tag", {28'd0, rsp_tag_o}, 32'd8);
    check("R7 new write data", {24'd0, rsp_data_o}, 32'h44);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule